// File: doc/BRIEF.md
# Clock Source Mode Controller

This block chooses the operating mode of a clock generator. It does not touch any clock itself. It takes the settings from a clock-control register: a 2-bit source selector, a reference-select bit (1 means internal, 0 means external) and a low-power request. It also takes a debug-active input and a stop-state input. From these it derives the mode: the frequency-locked loop either drives the output clock (engaged) or is bypassed, and it runs from either the internal or the external reference. It then drives registered enables for the loop, both reference clocks and the debug clock, plus a code that names the source of the output clock.

An active debug session keeps the loop running in the external-bypass mode, even when low power is requested, so the debug clock stays alive. The reference-status flag does not follow the reference-select bit at once. It waits until the divided-reference tick input has risen a set number of times after the last change. This models the loop relocking before the switch counts as complete. Software must move the reference divider together with the select bit so that the divided reference stays inside roughly 31.25 kHz to 39.0625 kHz. This block relies on that rule and does not check it.

Top module: `clk_mode_ctrl`

## Requirements
- R1: Selector 00 gives mode code 0 (engaged, internal reference) when ref_int_sel is 1, and mode code 1 (engaged, external reference) when it is 0.
- R2: Selector 01 gives mode code 3 (internal bypass, low power) when lp_req is 1 and dbg_active is 0. Otherwise it gives mode code 2 (internal bypass). Both ignore ref_int_sel.
- R3: Selector 10 with ref_int_sel 0 gives mode code 4 (external bypass) when dbg_active is 1 or lp_req is 0. Outside stop, mode 4 drives loop_en, dbg_clk_en and ext_ref_en to 1.
- R4: Selector 10 with ref_int_sel 0, lp_req 1 and dbg_active 0 gives mode code 5 (external bypass, low power). In mode 5, loop_en and dbg_clk_en are 0 and ext_ref_en is 1.
- R5: Selector 11, and selector 10 with ref_int_sel 1, keep the previous mode code.
- R6: out_src is 0 (loop) in modes 0 and 1, 1 (internal reference) in modes 2 and 3, and 2 (external reference) in modes 4 and 5.
- R7: Outside stop, int_ref_en is 1 when the mode uses the internal reference (codes 0, 2, 3) or when irc_en is 1. ext_ref_en is 1 when the mode uses the external reference (codes 1, 4, 5) or when erc_en is 1. loop_en and dbg_clk_en are 1 in every mode except 3 and 5.
- R8: While stop_req is 1, loop_en and dbg_clk_en are 0, int_ref_en equals irc_en AND irc_stop_en, and ext_ref_en equals erc_en AND erc_stop_en.
- R9: All outputs are registered and change at the first rising clock edge after their inputs change. Reset values: mode 0, out_src 0, loop_en 1, dbg_clk_en 1, int_ref_en 1, ext_ref_en 0, ref_status 1.
- R10: ref_status takes the new value of ref_int_sel at the clock edge that samples the second rising edge of ref_tick after the change was seen. A rising edge sampled in the same cycle as the change is not counted.
- R11: If ref_int_sel changes again before the flag updates, the tick count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_src | input | 2 | Clock source selector field |
| ref_int_sel | input | 1 | Reference select: 1 internal, 0 external |
| lp_req | input | 1 | Low-power request for the bypass modes |
| dbg_active | input | 1 | Debug session active |
| stop_req | input | 1 | Device is in the stop state |
| irc_en | input | 1 | Internal reference clock output enable |
| irc_stop_en | input | 1 | Keep the internal reference running in stop |
| erc_en | input | 1 | External reference clock output enable |
| erc_stop_en | input | 1 | Keep the external reference running in stop |
| ref_tick | input | 1 | Divided-reference tick (level) |
| mode | output | 3 | Current mode code (0 to 5) |
| out_src | output | 2 | Output clock source: 0 loop, 1 internal, 2 external |
| loop_en | output | 1 | Locked loop enable |
| dbg_clk_en | output | 1 | Debug clock available |
| int_ref_en | output | 1 | Internal reference enable |
| ext_ref_en | output | 1 | External reference enable |
| ref_status | output | 1 | Reference in use after the switch completes |

## Verification
The hardest case to reach from the ports is a reference switch that is cut short. The select bit must flip back and then forth again after one tick has already been counted, and the bench must then show that the next single tick still does not complete the switch. The stimulus toggles ref_int_sel on consecutive cycles in the middle of a tick train. A separate case raises the tick in the same cycle as the select change. Both cases run while the selector holds an internal-bypass mode, so the mode never changes and the status flag is the only output that moves.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  typedef enum logic [2:0] {
    M_ENG_INT    = 3'd0,
    M_ENG_EXT    = 3'd1,
    M_BYP_INT    = 3'd2,
    M_BYP_INT_LP = 3'd3,
    M_BYP_EXT    = 3'd4,
    M_BYP_EXT_LP = 3'd5
  } clk_mode_e;

  typedef enum logic [1:0] {
    SRC_LOOP = 2'd0,
    SRC_INT  = 2'd1,
    SRC_EXT  = 2'd2
  } clk_src_e;

  function automatic logic mode_uses_int(clk_mode_e m);
    return (m == M_ENG_INT) || (m == M_BYP_INT) || (m == M_BYP_INT_LP);
  endfunction

  function automatic logic mode_runs_loop(clk_mode_e m);
    return (m != M_BYP_INT_LP) && (m != M_BYP_EXT_LP);
  endfunction

  function automatic clk_src_e mode_source(clk_mode_e m);
    case (m)
      M_ENG_INT, M_ENG_EXT:    return SRC_LOOP;
      M_BYP_INT, M_BYP_INT_LP: return SRC_INT;
      default:                 return SRC_EXT;
    endcase
  endfunction

endpackage

// File: rtl/clk_mode_decode.sv
module clk_mode_decode
  import clk_mode_pkg::*;
(
  input  logic [1:0] sel_src,
  input  logic       ref_int_sel,
  input  logic       lp_req,
  input  logic       dbg_active,
  input  clk_mode_e  cur_mode,
  output clk_mode_e  nxt_mode,
  output logic       hold_evt
);

  logic lp_granted;
  assign lp_granted = lp_req && !dbg_active;

  always_comb begin
    nxt_mode = cur_mode;
    hold_evt = 1'b0;
    case (sel_src)
      2'b00: nxt_mode = ref_int_sel ? M_ENG_INT : M_ENG_EXT;
      2'b01: nxt_mode = lp_granted ? M_BYP_INT_LP : M_BYP_INT;
      2'b10: begin
        if (!ref_int_sel) nxt_mode = lp_granted ? M_BYP_EXT_LP : M_BYP_EXT;
        else              hold_evt = 1'b1;
      end
      default: hold_evt = 1'b1;
    endcase
  end

endmodule

// File: rtl/clk_mode_regs.sv
module clk_mode_regs
  import clk_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  clk_mode_e nxt_mode,
  input  logic      stop_req,
  input  logic      irc_en,
  input  logic      irc_stop_en,
  input  logic      erc_en,
  input  logic      erc_stop_en,
  output clk_mode_e mode_q,
  output clk_src_e  src_q,
  output logic      loop_en,
  output logic      dbg_clk_en,
  output logic      int_ref_en,
  output logic      ext_ref_en
);

  logic run_loop_d, int_d, ext_d;

  always_comb begin
    if (stop_req) begin
      run_loop_d = 1'b0;
      int_d      = irc_en && irc_stop_en;
      ext_d      = erc_en && erc_stop_en;
    end else begin
      run_loop_d = mode_runs_loop(nxt_mode);
      int_d      = mode_uses_int(nxt_mode) || irc_en;
      ext_d      = !mode_uses_int(nxt_mode) || erc_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_ENG_INT;
      src_q      <= SRC_LOOP;
      loop_en    <= 1'b1;
      dbg_clk_en <= 1'b1;
      int_ref_en <= 1'b1;
      ext_ref_en <= 1'b0;
    end else begin
      mode_q     <= nxt_mode;
      src_q      <= mode_source(nxt_mode);
      loop_en    <= run_loop_d;
      dbg_clk_en <= run_loop_d;
      int_ref_en <= int_d;
      ext_ref_en <= ext_d;
    end
  end

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!loop_en && !dbg_clk_en)); // R8
  AST_STOP_INT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (int_ref_en == $past(irc_en && irc_stop_en))); // R8
  AST_LP_NO_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_req && (nxt_mode == M_BYP_EXT_LP || nxt_mode == M_BYP_INT_LP)) |=> !loop_en); // R4

endmodule

// File: rtl/clk_ref_settle.sv
module clk_ref_settle #(
  parameter int SETTLE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_int_sel,
  input  logic ref_tick,
  output logic ref_status,
  output logic sel_change,
  output logic tick_rise
);

  localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

  logic             sel_seen, tick_q, busy;
  logic [CNT_W-1:0] cnt;

  assign sel_change = (ref_int_sel != sel_seen);
  assign tick_rise  = ref_tick && !tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_seen   <= 1'b1;
      tick_q     <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      ref_status <= 1'b1;
    end else begin
      tick_q <= ref_tick;
      if (sel_change) begin
        sel_seen <= ref_int_sel;
        busy     <= 1'b1;
        cnt      <= '0;
      end else if (busy && tick_rise) begin
        if (cnt == LAST) begin
          ref_status <= sel_seen;
          busy       <= 1'b0;
          cnt        <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_rise |=> $stable(ref_status)); // R10
  AST_SWITCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> (cnt == '0)); // R11

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int SETTLE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_src,
  input  logic       ref_int_sel,
  input  logic       lp_req,
  input  logic       dbg_active,
  input  logic       stop_req,
  input  logic       irc_en,
  input  logic       irc_stop_en,
  input  logic       erc_en,
  input  logic       erc_stop_en,
  input  logic       ref_tick,
  output logic [2:0] mode,
  output logic [1:0] out_src,
  output logic       loop_en,
  output logic       dbg_clk_en,
  output logic       int_ref_en,
  output logic       ext_ref_en,
  output logic       ref_status
);

  clk_mode_e mode_q, nxt_mode;
  clk_src_e  src_q;
  logic      hold_evt, sel_change, tick_rise;

  clk_mode_decode u_decode (
    .sel_src(sel_src), .ref_int_sel(ref_int_sel), .lp_req(lp_req),
    .dbg_active(dbg_active), .cur_mode(mode_q), .nxt_mode(nxt_mode),
    .hold_evt(hold_evt)
  );

  clk_mode_regs u_regs (
    .clk(clk), .rst_n(rst_n), .nxt_mode(nxt_mode), .stop_req(stop_req),
    .irc_en(irc_en), .irc_stop_en(irc_stop_en), .erc_en(erc_en),
    .erc_stop_en(erc_stop_en), .mode_q(mode_q), .src_q(src_q),
    .loop_en(loop_en), .dbg_clk_en(dbg_clk_en), .int_ref_en(int_ref_en),
    .ext_ref_en(ext_ref_en)
  );

  clk_ref_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_n), .ref_int_sel(ref_int_sel), .ref_tick(ref_tick),
    .ref_status(ref_status), .sel_change(sel_change), .tick_rise(tick_rise)
  );

  assign mode    = mode_q;
  assign out_src = src_q;

  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> (mode == $past(mode))); // R5
  AST_DBG_KEEPS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_src == 2'b10 && !ref_int_sel && dbg_active && !stop_req)
      |=> (loop_en && dbg_clk_en && mode == 3'd4)); // R3
  AST_STOP_EXT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (ext_ref_en == $past(erc_en && erc_stop_en))); // R8

endmodule

// File: tb/clk_mode_ctrl_test.sv
module clk_mode_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_src = 2'b00;
  logic       ref_int_sel = 1'b1, lp_req = 1'b0, dbg_active = 1'b0, stop_req = 1'b0;
  logic       irc_en = 1'b0, irc_stop_en = 1'b0, erc_en = 1'b0, erc_stop_en = 1'b0;
  logic       ref_tick = 1'b0;
  logic [2:0] mode;
  logic [1:0] out_src;
  logic       loop_en, dbg_clk_en, int_ref_en, ext_ref_en, ref_status;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [8:0] val;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  clk_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sel_src(sel_src), .ref_int_sel(ref_int_sel),
    .lp_req(lp_req), .dbg_active(dbg_active), .stop_req(stop_req),
    .irc_en(irc_en), .irc_stop_en(irc_stop_en), .erc_en(erc_en),
    .erc_stop_en(erc_stop_en), .ref_tick(ref_tick), .mode(mode),
    .out_src(out_src), .loop_en(loop_en), .dbg_clk_en(dbg_clk_en),
    .int_ref_en(int_ref_en), .ext_ref_en(ext_ref_en), .ref_status(ref_status)
  );

  function automatic logic [8:0] pack_out();
    return {mode, out_src, loop_en, dbg_clk_en, int_ref_en, ext_ref_en, ref_status};
  endfunction

  // Expected outputs restated from R6, R7 and R8 for a given mode code.
  function automatic logic [8:0] predict(logic [2:0] m, logic st);
    logic [1:0] s;
    logic lp, ir, er;
    s = (m <= 3'd1) ? 2'd0 : ((m <= 3'd3) ? 2'd1 : 2'd2);
    if (stop_req) begin
      lp = 1'b0;
      ir = irc_en & irc_stop_en;
      er = erc_en & erc_stop_en;
    end else begin
      lp = !(m == 3'd3 || m == 3'd5);
      ir = (m == 3'd0 || m == 3'd2 || m == 3'd3) | irc_en;
      er = (m == 3'd1 || m == 3'd4 || m == 3'd5) | erc_en;
    end
    return {m, s, lp, lp, ir, er, st};
  endfunction

  task automatic step(string tag, logic [2:0] m, logic st);
    exp_t e;
    e.tag = tag;
    e.val = predict(m, st);
    sb.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        logic [8:0] act;
        e = sb.pop_front();
        act = pack_out();
        checks++;
        if (act !== e.val) begin
          errors++;
          $display("FAIL %s: actual %b expected %b (mode,src,loop,dbg,iref,eref,status)",
                   e.tag, act, e.val);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pack_out() !== 9'b000_00_1110_1) begin
      errors++;
      $display("FAIL R9 reset: actual %b expected %b", pack_out(), 9'b000_00_1110_1);
    end
    rst_n = 1'b1;
    step("R9 after reset", 3'd0, 1'b1);
    ref_int_sel = 1'b0;           step("R1 engaged external", 3'd1, 1'b1);
    ref_tick = 1'b1;              step("R10 first tick", 3'd1, 1'b1);
    ref_tick = 1'b0;              step("R10 tick low", 3'd1, 1'b1);
    ref_tick = 1'b1;              step("R10 second tick", 3'd1, 1'b0);
    ref_tick = 1'b0;
    sel_src = 2'b01;              step("R2 internal bypass", 3'd2, 1'b0);
    lp_req = 1'b1;                step("R2 internal bypass low power", 3'd3, 1'b0);
    dbg_active = 1'b1;            step("R2 debug overrides low power", 3'd2, 1'b0);
    dbg_active = 1'b0; lp_req = 1'b0;
    sel_src = 2'b10;              step("R3 external bypass", 3'd4, 1'b0);
    lp_req = 1'b1; dbg_active = 1'b1; step("R3 debug keeps loop", 3'd4, 1'b0);
    dbg_active = 1'b0;            step("R4 external bypass low power", 3'd5, 1'b0);
    sel_src = 2'b11;              step("R5 reserved holds", 3'd5, 1'b0);
    sel_src = 2'b10; ref_int_sel = 1'b1; step("R5 selector 10 internal holds", 3'd5, 1'b0);
    ref_int_sel = 1'b0; lp_req = 1'b0;
    sel_src = 2'b00; irc_en = 1'b1; step("R7 irc_en forces internal ref", 3'd1, 1'b0);
    irc_en = 1'b0; sel_src = 2'b01; erc_en = 1'b1; step("R7 R6 erc_en forces external ref", 3'd2, 1'b0);
    stop_req = 1'b1; irc_en = 1'b1; irc_stop_en = 1'b0; erc_stop_en = 1'b1;
    step("R8 stop keeps external only", 3'd2, 1'b0);
    irc_stop_en = 1'b1; erc_stop_en = 1'b0; step("R8 stop keeps internal only", 3'd2, 1'b0);
    irc_en = 1'b0; erc_en = 1'b0; erc_stop_en = 1'b1; step("R8 stop with enables off", 3'd2, 1'b0);
    stop_req = 1'b0; irc_stop_en = 1'b0; erc_stop_en = 1'b0;
    step("R8 leave stop", 3'd2, 1'b0);
    ref_int_sel = 1'b1;           step("R11 switch to internal", 3'd2, 1'b0);
    ref_tick = 1'b1;              step("R11 one tick", 3'd2, 1'b0);
    ref_tick = 1'b0; ref_int_sel = 1'b0; step("R11 switch back", 3'd2, 1'b0);
    ref_int_sel = 1'b1;           step("R11 switch again", 3'd2, 1'b0);
    ref_tick = 1'b1;              step("R11 single tick after restart", 3'd2, 1'b0);
    ref_tick = 1'b0;              step("R11 tick low", 3'd2, 1'b0);
    ref_tick = 1'b1;              step("R11 completes", 3'd2, 1'b1);
    ref_tick = 1'b0;              step("R10 idle", 3'd2, 1'b1);
    ref_int_sel = 1'b0; ref_tick = 1'b1; step("R10 tick with change not counted", 3'd2, 1'b1);
    ref_tick = 1'b0;              step("R10 low", 3'd2, 1'b1);
    ref_tick = 1'b1;              step("R10 first counted tick", 3'd2, 1'b1);
    ref_tick = 1'b0;              step("R10 low again", 3'd2, 1'b1);
    ref_tick = 1'b1;              step("R10 second counted tick", 3'd2, 1'b0);
    ref_tick = 1'b0;
    sel_src = 2'b00;              step("R1 back to engaged external", 3'd1, 1'b0);
    ref_int_sel = 1'b1;           step("R1 engaged internal", 3'd0, 1'b0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule